// File: doc/BRIEF.md
# Raster timing generator with drained stop

The block turns a handful of programmed timing words into a raster: a horizontal sync, a vertical sync, a data-enable, the coordinates of the active pixel and a field flag. Each line runs sync, back porch, active, front porch. Each frame has the same vertical order, counted in lines. Software programs the timing through a simple register write/read port. It then sets the run bit, and the raster starts at the first sync pixel.

Clearing the run bit is a request, not a cut. The frame in progress runs to its last pixel. The generator then goes idle and raises a frame-done event in an interrupt block. That block has a raw view, a masked view, a write-one-to-set mask port and a write-one-to-clear mask port. In interlaced mode two fields make a frame, and each field is as tall as the programmed line count. The second field moves its vertical sync half a line later. Timing words are copied into a working set only when a frame begins, so reprogramming never tears a frame.

Top module: `raster_gen`

## Requirements
- R1: After reset the generator is idle: busy 0, data-enable 0, irq 0, both syncs at the inactive level of active-low polarity (1), the pixel coordinates 0, and every register reads 0.
- R2: The horizontal timing word (address 2) holds back porch in bits 31:20, front porch in bits 19:8 and sync width in bits 7:0. The vertical timing word (address 3) uses the same layout in lines. Each line is ordered sync, back porch, active, front porch, and each frame has the same order.
- R3: The size word (address 1) holds the active line count in bits 31:16 and the active pixel count in bits 15:0. The data-enable is high only in the active window. There, pix_x and pix_y count from 0, and outside it they are 0.
- R4: Config word (address 0) bit 7 makes vsync active-high, and bit 6 does the same for hsync. When the bit is 0 the sync is active-low. While idle, each sync sits at its inactive level.
- R5: Config bit 31 is the run bit. Setting it while idle starts the raster at horizontal and vertical position 0, which is the first sync pixel. busy rises two clock edges after the edge that takes the write.
- R6: Clearing the run bit lets the frame in progress finish. busy falls only after the last pixel of the frame, and then bit 0 of the raw status is set.
- R7: Config bit 3 selects interlace. Fields 0 and 1 alternate, each using the programmed line count, and the field output shows the current field. In field 1, vsync starts and ends half a line (total pixels / 2) later. A stop takes effect only after field 1.
- R8: Writes to the timing, size and polarity fields take effect only at the start of the next frame.
- R9: Address 4 reads the raw status and address 5 reads raw AND mask. A write to address 6 sets mask bits, and a write to address 7 clears them. The mask resets to 0, and irq is the registered OR of raw AND mask.
- R10: Writing a 1 to a bit at address 5 clears that raw bit, and a read issued in the next cycle returns the cleared value. A new event in the same cycle wins over the clear.
- R11: A read returns data on rd_data one clock edge after rd_en, and rd_data holds its value between reads. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register write address |
| wr_data | input | 32 | register write data |
| rd_en | input | 1 | register read strobe |
| rd_addr | input | 3 | register read address |
| rd_data | output | 32 | registered read data |
| hsync | output | 1 | horizontal sync, polarity per config |
| vsync | output | 1 | vertical sync, polarity per config |
| de | output | 1 | active-video data-enable |
| pix_x | output | 16 | active pixel column |
| pix_y | output | 16 | active line within the field |
| field | output | 1 | current interlace field |
| busy | output | 1 | raster running |
| irq | output | 1 | interrupt request |

## Verification
A register write lands on the edge that samples it. The engine reacts to a new run bit at the next edge, and its registered outputs show the change one edge after that, so busy and the first sync pixel appear two edges after the write edge. A frame-done event goes through three registers in turn: the internal done pulse, then the raw bit, then irq. Reads return on the edge after rd_en. The bench's behavioural model applies exactly this latency chain on each rising edge and compares every output at the falling edge. The explicit checks wait the same counted number of falling edges before they sample.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int PORCH_W = 12;
  localparam int SYNC_W = 8;
  localparam int ACT_W = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG  = 3'd0,
    A_SIZE = 3'd1,
    A_HTIM = 3'd2,
    A_VTIM = 3'd3,
    A_RAW  = 3'd4,
    A_STAT = 3'd5,
    A_ESET = 3'd6,
    A_ECLR = 3'd7
  } reg_addr_e;

  // packed order matches the timing word: back porch, front porch, sync
  typedef struct packed {
    logic [PORCH_W-1:0] bp;
    logic [PORCH_W-1:0] fp;
    logic [SYNC_W-1:0]  sw;
  } axis_tim_t;

  typedef struct packed {
    axis_tim_t        h;
    axis_tim_t        v;
    logic [ACT_W-1:0] hact;
    logic [ACT_W-1:0] vact;
    logic             vpol;
    logic             hpol;
    logic             ilace;
  } timing_t;
endpackage

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
#(
  parameter int IRQ_N = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IRQ_N-1:0]  evt_i,
  output timing_t           tim_o,
  output logic              run_o,
  output logic              irq_o
);
  logic              run_q, vpol_q, hpol_q, il_q;
  logic [DATA_W-1:0] size_q, htim_q, vtim_q;
  logic [IRQ_N-1:0]  raw_q, mask_q, clr;
  logic [DATA_W-1:0] rd_mux;

  assign clr = (wr_en && wr_addr == A_STAT) ? wr_data[IRQ_N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      vpol_q <= 1'b0;
      hpol_q <= 1'b0;
      il_q   <= 1'b0;
      size_q <= '0;
      htim_q <= '0;
      vtim_q <= '0;
      mask_q <= '0;
      raw_q  <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_CFG: begin
            run_q  <= wr_data[31];
            vpol_q <= wr_data[7];
            hpol_q <= wr_data[6];
            il_q   <= wr_data[3];
          end
          A_SIZE: size_q <= wr_data;
          A_HTIM: htim_q <= wr_data;
          A_VTIM: vtim_q <= wr_data;
          A_ESET: mask_q <= mask_q | wr_data[IRQ_N-1:0];
          A_ECLR: mask_q <= mask_q & ~wr_data[IRQ_N-1:0];
          default: ;
        endcase
      end
      // a fresh event wins over a clear in the same cycle
      raw_q <= (raw_q & ~clr) | evt_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      A_CFG: begin
        rd_mux[31] = run_q;
        rd_mux[7]  = vpol_q;
        rd_mux[6]  = hpol_q;
        rd_mux[3]  = il_q;
      end
      A_SIZE:  rd_mux = size_q;
      A_HTIM:  rd_mux = htim_q;
      A_VTIM:  rd_mux = vtim_q;
      A_RAW:   rd_mux = DATA_W'(raw_q);
      A_STAT:  rd_mux = DATA_W'(raw_q & mask_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq_o   <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_mux;
      irq_o <= |(raw_q & mask_q);
    end
  end

  assign run_o = run_q;
  assign tim_o = '{h: axis_tim_t'(htim_q), v: axis_tim_t'(vtim_q),
                   hact: size_q[15:0], vact: size_q[31:16],
                   vpol: vpol_q, hpol: hpol_q, ilace: il_q};

  // R9
  mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_ECLR && wr_data[0]) |=> !mask_q[0]);
  // R10
  raw_set_chk: assert property (@(posedge clk) disable iff (rst)
    evt_i[0] |=> raw_q[0]);
  // R10
  raw_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_STAT && wr_data[0] && !evt_i[0]) |=> !raw_q[0]);
endmodule

// File: rtl/raster_engine.sv
module raster_engine
  import raster_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  timing_t          tim_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [ACT_W-1:0] x_o,
  output logic [ACT_W-1:0] y_o,
  output logic             field_o,
  output logic             busy_o,
  output logic             done_o
);
  timing_t          sh;
  logic             run_q, fld_q, done_q;
  logic [CNT_W-1:0] h_q, v_q;
  logic [CNT_W-1:0] hlo, hhi, htot, vlo, vhi, vtot, half;
  logic             last_h, last_v, last_fld;
  logic             hs_act, vs_act, de_act;

  // working-set derived boundaries
  assign hlo  = CNT_W'(sh.h.sw) + CNT_W'(sh.h.bp);
  assign hhi  = hlo + CNT_W'(sh.hact);
  assign htot = hhi + CNT_W'(sh.h.fp);
  assign vlo  = CNT_W'(sh.v.sw) + CNT_W'(sh.v.bp);
  assign vhi  = vlo + CNT_W'(sh.vact);
  assign vtot = vhi + CNT_W'(sh.v.fp);
  assign half = htot >> 1;

  assign last_h   = (h_q == htot - 1'b1);
  assign last_v   = (v_q == vtot - 1'b1);
  assign last_fld = !sh.ilace || fld_q;

  always_comb begin
    hs_act = run_q && (h_q < CNT_W'(sh.h.sw));
    if (sh.ilace && fld_q)
      vs_act = run_q && (((v_q == '0) && (h_q >= half)) ||
                         ((v_q != '0) && (v_q < CNT_W'(sh.v.sw))) ||
                         ((v_q == CNT_W'(sh.v.sw)) && (h_q < half)));
    else
      vs_act = run_q && (v_q < CNT_W'(sh.v.sw));
    de_act = run_q && (h_q >= hlo) && (h_q < hhi) && (v_q >= vlo) && (v_q < vhi);
  end

  // raster counters and working-set reload
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      fld_q  <= 1'b0;
      h_q    <= '0;
      v_q    <= '0;
      sh     <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!run_q) begin
        if (run_i) begin
          run_q <= 1'b1;
          h_q   <= '0;
          v_q   <= '0;
          fld_q <= 1'b0;
          sh    <= tim_i;
        end
      end else if (last_h) begin
        h_q <= '0;
        if (last_v) begin
          v_q <= '0;
          if (last_fld) begin
            fld_q <= 1'b0;
            if (run_i) begin
              sh <= tim_i;
            end else begin
              run_q  <= 1'b0;
              done_q <= 1'b1;
            end
          end else begin
            fld_q <= 1'b1;
          end
        end else begin
          v_q <= v_q + 1'b1;
        end
      end else begin
        h_q <= h_q + 1'b1;
      end
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o <= 1'b1;
      vsync_o <= 1'b1;
      de_o    <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
      field_o <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      hsync_o <= hs_act ~^ sh.hpol;
      vsync_o <= vs_act ~^ sh.vpol;
      de_o    <= de_act;
      x_o     <= de_act ? ACT_W'(h_q - hlo) : '0;
      y_o     <= de_act ? ACT_W'(v_q - vlo) : '0;
      field_o <= run_q & fld_q;
      busy_o  <= run_q;
    end
  end

  assign done_o = done_q;

  // R2
  h_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (h_q < htot));
  // R6
  stop_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> (h_q == '0 && v_q == '0 && done_q));
  // R6
  done_needs_stop_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !$past(run_i));
  // R3
  de_busy_chk: assert property (@(posedge clk) disable iff (rst)
    de_o |-> busy_o);
endmodule

// File: rtl/raster_gen.sv
module raster_gen
  import raster_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        hsync,
  output logic        vsync,
  output logic        de,
  output logic [15:0] pix_x,
  output logic [15:0] pix_y,
  output logic        field,
  output logic        busy,
  output logic        irq
);
  localparam int IRQ_N = 1;

  timing_t          tim;
  logic             run_req;
  logic             done;
  logic [IRQ_N-1:0] evt;

  assign evt = IRQ_N'(done);

  raster_regs #(.IRQ_N(IRQ_N)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_i(evt), .tim_o(tim), .run_o(run_req), .irq_o(irq)
  );

  raster_engine #(.CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst(rst), .run_i(run_req), .tim_i(tim),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de),
    .x_o(pix_x), .y_o(pix_y), .field_o(field),
    .busy_o(busy), .done_o(done)
  );
endmodule

// File: tb/tb_raster_gen.sv
module tb_raster_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        hsync, vsync, de, field, busy, irq;
  logic [15:0] pix_x, pix_y;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  string phase = "R1";

  raster_gen dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  int m_run, m_h, m_v, m_fld, m_done, m_raw, m_mask;
  int c_en, c_vp, c_hp, c_il;
  logic [31:0] c_size, c_htim, c_vtim;
  int s_hsw, s_hbp, s_hfp, s_hact, s_vsw, s_vbp, s_vfp, s_vact, s_hp, s_vp, s_il;
  int e_hs, e_vs, e_de, e_x, e_y, e_fld, e_busy, e_irq;
  logic [31:0] e_rd;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s (phase %s) at cycle %0d: actual=%0h expected=%0h", tag, phase, cyc, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: model_read = {c_en[0], 23'd0, c_vp[0], c_hp[0], 2'd0, c_il[0], 3'd0};
      3'd1: model_read = c_size;
      3'd2: model_read = c_htim;
      3'd3: model_read = c_vtim;
      3'd4: model_read = 32'(m_raw);
      3'd5: model_read = 32'(m_raw & m_mask);
      default: model_read = 32'd0;
    endcase
  endfunction

  task automatic load_shadow();
    s_hbp = int'(c_htim[31:20]); s_hfp = int'(c_htim[19:8]); s_hsw = int'(c_htim[7:0]);
    s_vbp = int'(c_vtim[31:20]); s_vfp = int'(c_vtim[19:8]); s_vsw = int'(c_vtim[7:0]);
    s_vact = int'(c_size[31:16]); s_hact = int'(c_size[15:0]);
    s_hp = c_hp; s_vp = c_vp; s_il = c_il;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_h = 0; m_v = 0; m_fld = 0; m_done = 0; m_raw = 0; m_mask = 0;
      c_en = 0; c_vp = 0; c_hp = 0; c_il = 0; c_size = 0; c_htim = 0; c_vtim = 0;
      s_hsw = 0; s_hbp = 0; s_hfp = 0; s_hact = 0; s_vsw = 0; s_vbp = 0; s_vfp = 0; s_vact = 0;
      s_hp = 0; s_vp = 0; s_il = 0;
      e_hs = 1; e_vs = 1; e_de = 0; e_x = 0; e_y = 0; e_fld = 0; e_busy = 0; e_irq = 0; e_rd = 0;
    end else begin
      int htot, vtot, half, hlo, vlo, nd;
      bit hs_a, vs_a, de_a;
      hlo = s_hsw + s_hbp; vlo = s_vsw + s_vbp;
      htot = hlo + s_hact + s_hfp; vtot = vlo + s_vact + s_vfp; half = htot / 2;
      hs_a = m_run != 0 && m_h < s_hsw;
      if (s_il != 0 && m_fld != 0)
        vs_a = m_run != 0 && ((m_v == 0 && m_h >= half) || (m_v > 0 && m_v < s_vsw) ||
                              (m_v == s_vsw && m_h < half));
      else
        vs_a = m_run != 0 && m_v < s_vsw;
      de_a = m_run != 0 && m_h >= hlo && m_h < hlo + s_hact && m_v >= vlo && m_v < vlo + s_vact;
      e_hs = (int'(hs_a) == s_hp) ? 1 : 0;
      e_vs = (int'(vs_a) == s_vp) ? 1 : 0;
      e_de = de_a; e_x = de_a ? m_h - hlo : 0; e_y = de_a ? m_v - vlo : 0;
      e_fld = (m_run != 0 && m_fld != 0) ? 1 : 0;
      e_busy = m_run; e_irq = ((m_raw & m_mask) != 0) ? 1 : 0;
      if (rd_en) e_rd = model_read(rd_addr);
      nd = 0;
      if (m_run == 0) begin
        if (c_en != 0) begin m_run = 1; m_h = 0; m_v = 0; m_fld = 0; load_shadow(); end
      end else if (m_h == htot - 1) begin
        m_h = 0;
        if (m_v == vtot - 1) begin
          m_v = 0;
          if (s_il == 0 || m_fld == 1) begin
            m_fld = 0;
            if (c_en != 0) load_shadow();
            else begin m_run = 0; nd = 1; end
          end else m_fld = 1;
        end else m_v++;
      end else m_h++;
      if (wr_en && wr_addr == 3'd5 && wr_data[0]) m_raw = 0;
      m_raw = m_raw | m_done;
      m_done = nd;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin c_en = wr_data[31]; c_vp = wr_data[7]; c_hp = wr_data[6]; c_il = wr_data[3]; end
          3'd1: c_size = wr_data;
          3'd2: c_htim = wr_data;
          3'd3: c_vtim = wr_data;
          3'd6: if (wr_data[0]) m_mask = 1;
          3'd7: if (wr_data[0]) m_mask = 0;
          default: ;
        endcase
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R2 hsync", hsync, e_hs);
      chk("R2 vsync", vsync, e_vs);
      chk("R3 de", de, e_de);
      chk("R3 pix_x", pix_x, e_x);
      chk("R3 pix_y", pix_y, e_y);
      chk("R7 field", field, e_fld);
      chk("R6 busy", busy, e_busy);
      chk("R9 irq", irq, e_irq);
      chk("R11 rd_data", rd_data, e_rd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rd_data, exp);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  localparam logic [31:0] HT0 = (32'd3 << 20) | (32'd2 << 8) | 32'd2;
  localparam logic [31:0] HT1 = (32'd3 << 20) | (32'd2 << 8) | 32'd3;
  localparam logic [31:0] VT0 = (32'd2 << 20) | (32'd1 << 8) | 32'd1;
  localparam logic [31:0] VT1 = (32'd1 << 20) | (32'd1 << 8) | 32'd2;
  localparam logic [31:0] SZ0 = (32'd3 << 16) | 32'd5;

  initial begin
    bit seen_f1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 hsync", hsync, 1); chk("R1 de", de, 0); chk("R1 irq", irq, 0);
    rd(3'd0, 32'd0, "R1 cfg"); rd(3'd2, 32'd0, "R1 htim");
    wr(3'd3, VT0); wr(3'd2, HT0); wr(3'd1, SZ0);
    rd(3'd2, HT0, "R2 htim readback");
    rd(3'd1, SZ0, "R3 size readback");
    // R5 start: busy and first sync pixel two edges after the write edge
    phase = "R5";
    wr(3'd0, 32'h8000_0000);
    chk("R5 busy early", busy, 0);
    repeat (2) @(negedge clk);
    chk("R5 busy", busy, 1); chk("R5 hsync at start", hsync, 0); chk("R5 vsync at start", vsync, 0);
    repeat (170) @(negedge clk);
    // R8 reprogram mid-frame; model applies it at the next frame start
    phase = "R8";
    repeat (20) @(negedge clk);
    wr(3'd2, HT1); wr(3'd3, VT1);
    rd(3'd2, HT1, "R8 htim readback");
    repeat (250) @(negedge clk);
    // R6 drained stop with mask still 0
    phase = "R6";
    repeat (17) @(negedge clk);
    wr(3'd0, 32'h0);
    chk("R6 still busy after stop request", busy, 1);
    wait_idle();
    chk("R6 idle", busy, 0);
    rd(3'd4, 32'd1, "R6 raw done");
    phase = "R9";
    chk("R9 irq masked off", irq, 0);
    rd(3'd5, 32'd0, "R9 masked status with mask 0");
    wr(3'd6, 32'd1);
    @(negedge clk);
    chk("R9 irq after mask set", irq, 1);
    rd(3'd5, 32'd1, "R9 masked status");
    rd(3'd6, 32'd0, "R11 set port reads 0");
    rd(3'd7, 32'd0, "R11 clear port reads 0");
    phase = "R10";
    wr(3'd5, 32'd1);
    rd(3'd4, 32'd0, "R10 raw cleared");
    chk("R10 irq dropped", irq, 0);
    @(negedge clk);
    chk("R11 rd_data holds", rd_data, 0);
    // R4 active-high syncs
    phase = "R4";
    wr(3'd0, 32'h8000_00C0);
    repeat (300) @(negedge clk);
    wr(3'd0, 32'h0000_00C0);
    wait_idle();
    chk("R4 idle hsync low", hsync, 0); chk("R4 idle vsync low", vsync, 0);
    rd(3'd0, 32'h0000_00C0, "R4 cfg readback");
    chk("R9 irq on second done", irq, 1);
    wr(3'd7, 32'd1);
    rd(3'd5, 32'd0, "R9 mask cleared");
    wr(3'd5, 32'd1);
    // R7 interlace: two fields per frame, offset vsync in field 1
    phase = "R7";
    seen_f1 = 0;
    wr(3'd0, 32'h8000_0008);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (field) seen_f1 = 1;
    end
    wr(3'd0, 32'h0000_0008);
    wait_idle();
    chk("R7 field 1 seen", seen_f1, 1);
    chk("R7 idle field", field, 0);
    rd(3'd4, 32'd1, "R7 done after field pair");
    finish_run();
  end
endmodule